// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Register Block

This block sits beside one channel of a DMA controller and gives the processor a 16-bit register view of that channel's event status, its interrupt enables and its two 32-bit start addresses. Six single-cycle event strobes from the channel engine record themselves as status bits, but only for sources the processor has enabled. Any recorded enabled bit raises a level interrupt request.

The processor reads status through a read port with a debugger flag. An ordinary read returns the status and then empties it. A read flagged as a debugger access returns the same value and changes nothing. While the interrupt request is high, further events only add bits to the status. A new interrupt can only begin after a clearing read. An event that lands in the same cycle as a clearing read is kept, and it re-raises the request after a one-cycle gap.

The source and destination start addresses are each built from a high and a low 16-bit register. Both halves can be read and written, and they have no reset value.

Top module: `dma_chan_irq_regs`

## Requirements
- R1: After reset, the status bits, enable bits, `irq` and `reg_rdata` are all zero, and reads of the control (address 0) and status (address 1) registers return 0.
- R2: `evt_i[i]` pulsed for one cycle sets status bit i at that clock edge only when enable bit i (control register bit i, written at address 0) is set. When the enable bit is clear, the status bit stays 0.
- R3: A read with `reg_re`=1, `reg_dbg`=0 and `reg_addr`=1 puts the status held before that edge on `reg_rdata` after the edge, and clears every status bit at the same edge.
- R4: A read with `reg_re`=1, `reg_dbg`=1 and `reg_addr`=1 returns the status and leaves every status bit unchanged.
- R5: `irq` rises at the same edge as the first enabled status bit. It stays high while further events arrive, and it is low after the edge of a clearing read.
- R6: An enabled event in the same cycle as a clearing read leaves its bit set after the clear. `irq` is low for exactly one cycle after that read and is high again at the next edge.
- R7: A write (`reg_we`=1) to address 1 changes neither the status nor `irq`.
- R8: Addresses 2 and 3 hold the low and high halves of `src_addr`, and addresses 4 and 5 hold the low and high halves of `dst_addr`. The high half occupies bits 31:16. Each half reads back what was written.
- R9: Status bits 15:6 and control bits 15:6 always read as 0, and addresses 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 6 | Event strobes from the channel engine; bit i maps to status bit i |
| reg_addr | input | 3 | Register word address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_re | input | 1 | Read strobe |
| reg_dbg | input | 1 | Marks a read as a debugger access (no side effect) |
| reg_rdata | output | 16 | Registered read data, valid one cycle after `reg_re` |
| irq | output | 1 | Level interrupt request |
| src_addr | output | 32 | Source start address |
| dst_addr | output | 32 | Destination start address |

## Verification
The hazardous overlap is a channel event landing in the same cycle as the clearing status read. The bench provokes it by driving the event strobe together with a functional read of address 1. It then judges three things: the read returns only the bits recorded earlier, `irq` drops for exactly one cycle, and `irq` returns with only the new bit left in status. A second overlap is also covered: events arriving while `irq` is already high must grow the status word without starting a new interrupt.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_STAT   = 3'd1,
    A_SRC_LO = 3'd2,
    A_SRC_HI = 3'd3,
    A_DST_LO = 3'd4,
    A_DST_HI = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int NUM_EVT = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_we,
  input  logic [NUM_EVT-1:0] en_wdata,
  input  logic [NUM_EVT-1:0] evt,
  input  logic               clr,
  output logic [NUM_EVT-1:0] stat_o,
  output logic [NUM_EVT-1:0] en_o,
  output logic               irq_o
);
  logic [NUM_EVT-1:0] en_q, stat_q, en_d, stat_d;
  logic               irq_q;

  always_comb begin
    en_d   = en_we ? en_wdata : en_q;
    // new events are gated by the enables in force this cycle
    stat_d = (clr ? '0 : stat_q) | (evt & en_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      stat_q <= stat_d;
      // a clearing read forces one low cycle, which is the lockout gap
      irq_q  <= !clr && (|(stat_d & en_d));
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/dma_addr_pair.sv
module dma_addr_pair #(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                we_lo,
  input  logic                we_hi,
  input  logic [HALF_W-1:0]   wdata,
  output logic [2*HALF_W-1:0] addr_o
);
  logic [HALF_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (we_lo) lo_q <= wdata;
    if (we_hi) hi_q <= wdata;
  end

  assign addr_o = {hi_q, lo_q};
endmodule

// File: rtl/dma_chan_irq_regs.sv
module dma_chan_irq_regs
  import dma_irq_pkg::*;
#(
  parameter int NUM_EVT = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_we,
  input  logic [REG_W-1:0]   reg_wdata,
  input  logic               reg_re,
  input  logic               reg_dbg,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               irq,
  output logic [2*REG_W-1:0] src_addr,
  output logic [2*REG_W-1:0] dst_addr
);
  localparam int NUM_PAIR = 2;

  logic [NUM_EVT-1:0] stat_w, en_w;
  logic               clr_w;
  logic [2*REG_W-1:0] pair_addr [NUM_PAIR];
  logic [REG_W-1:0]   rd_mux, rdata_q;

  assign clr_w = reg_re && !reg_dbg && (reg_addr == A_STAT);

  dma_irq_status #(.NUM_EVT(NUM_EVT)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .en_we    (reg_we && (reg_addr == A_CTRL)),
    .en_wdata (reg_wdata[NUM_EVT-1:0]),
    .evt      (evt_i),
    .clr      (clr_w),
    .stat_o   (stat_w),
    .en_o     (en_w),
    .irq_o    (irq)
  );

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(A_SRC_LO + 2*p);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(A_SRC_HI + 2*p);
    dma_addr_pair #(.HALF_W(REG_W)) u_pair (
      .clk    (clk),
      .we_lo  (reg_we && (reg_addr == LO_A)),
      .we_hi  (reg_we && (reg_addr == HI_A)),
      .wdata  (reg_wdata),
      .addr_o (pair_addr[p])
    );
  end

  assign src_addr = pair_addr[0];
  assign dst_addr = pair_addr[1];

  always_comb begin
    case (reg_addr)
      A_CTRL:   rd_mux = REG_W'(en_w);
      A_STAT:   rd_mux = REG_W'(stat_w);
      A_SRC_LO: rd_mux = pair_addr[0][REG_W-1:0];
      A_SRC_HI: rd_mux = pair_addr[0][2*REG_W-1:REG_W];
      A_DST_LO: rd_mux = pair_addr[1][REG_W-1:0];
      A_DST_HI: rd_mux = pair_addr[1][2*REG_W-1:REG_W];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (reg_re) rdata_q <= rd_mux;
    else             rdata_q <= '0;
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/dma_chan_irq_chk.sv
module dma_chan_irq_chk #(
  parameter int NUM_EVT = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_re,
  input logic               reg_dbg,
  input logic               reg_we,
  input logic [2:0]         reg_addr,
  input logic [15:0]        reg_rdata,
  input logic               irq,
  input logic [NUM_EVT-1:0] stat,
  input logic [NUM_EVT-1:0] en
);
  // R2
  status_gated_chk: assert property (@(posedge clk) disable iff (rst)
    ((stat & ~$past(stat) & ~$past(en)) == '0));

  // R3
  func_read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_re && !reg_dbg && reg_addr == 3'd1) |=> !irq);

  // R4
  dbg_read_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_re && reg_dbg && reg_addr == 3'd1) |=> ((stat & $past(stat)) == $past(stat)));

  // R5
  irq_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (|(stat & en)));

  // R7
  stat_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && !reg_re && reg_addr == 3'd1) |=> ((stat & $past(stat)) == $past(stat)));

  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_re && reg_addr <= 3'd1) |=> (reg_rdata[15:NUM_EVT] == '0));
endmodule

bind dma_chan_irq_regs dma_chan_irq_chk #(.NUM_EVT(NUM_EVT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_re    (reg_re),
  .reg_dbg   (reg_dbg),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .irq       (irq),
  .stat      (stat_w),
  .en        (en_w)
);

// File: tb/dma_chan_irq_regs_tb.sv
`timescale 1ns/1ps
module dma_chan_irq_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  evt_i = '0;
  logic [2:0]  reg_addr = '0;
  logic        reg_we = 1'b0, reg_re = 1'b0, reg_dbg = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;
  logic [31:0] src_addr, dst_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dma_chan_irq_regs #(.NUM_EVT(6)) u_dut (
    .clk(clk), .rst(rst), .evt_i(evt_i), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_dbg(reg_dbg), .reg_rdata(reg_rdata),
    .irq(irq), .src_addr(src_addr), .dst_addr(dst_addr)
  );

  // {enable[5:0], event[5:0], expected status[5:0]}
  localparam logic [17:0] VEC [5] = '{
    {6'h3F, 6'h01, 6'h01},
    {6'h0A, 6'h0F, 6'h0A},
    {6'h00, 6'h3F, 6'h00},
    {6'h21, 6'h3F, 6'h21},
    {6'h3F, 6'h20, 6'h20}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle with every input set; returns after the edge, settled
  task automatic cyc(input logic re, input logic dbg, input logic we, input logic [2:0] a,
                     input logic [15:0] wd, input logic [5:0] ev);
    @(negedge clk);
    reg_re = re; reg_dbg = dbg; reg_we = we; reg_addr = a; reg_wdata = wd; evt_i = ev;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 3'd0, 16'h0, 6'h0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 rdata", {16'd0, reg_rdata}, 32'd0);
    cyc(1, 1, 0, 3'd1, 0, 0); chk("R1 status", {16'd0, reg_rdata}, 32'd0);
    cyc(1, 0, 0, 3'd0, 0, 0); chk("R1 ctrl", {16'd0, reg_rdata}, 32'd0);

    // vector table: R2 R3 R4 R5
    foreach (VEC[i]) begin
      cyc(0, 0, 1, 3'd0, {10'd0, VEC[i][17:12]}, 0);
      cyc(0, 0, 0, 3'd0, 0, VEC[i][11:6]);
      chk("R5 irq after event", {31'd0, irq}, {31'd0, VEC[i][5:0] != 6'd0});
      cyc(1, 1, 0, 3'd1, 0, 0);
      chk("R2 dbg status", {16'd0, reg_rdata}, {26'd0, VEC[i][5:0]});
      cyc(1, 1, 0, 3'd1, 0, 0);
      chk("R4 dbg unchanged", {16'd0, reg_rdata}, {26'd0, VEC[i][5:0]});
      chk("R4 irq held", {31'd0, irq}, {31'd0, VEC[i][5:0] != 6'd0});
      cyc(1, 0, 0, 3'd1, 0, 0);
      chk("R3 func read value", {16'd0, reg_rdata}, {26'd0, VEC[i][5:0]});
      chk("R5 irq after clear", {31'd0, irq}, 32'd0);
      cyc(1, 0, 0, 3'd1, 0, 0);
      chk("R3 cleared", {16'd0, reg_rdata}, 32'd0);
    end

    // R5 lockout: events while irq high add bits only
    cyc(0, 0, 1, 3'd0, 16'h003F, 0);
    cyc(0, 0, 0, 3'd0, 0, 6'h01);
    chk("R5 irq up", {31'd0, irq}, 32'd1);
    cyc(0, 0, 0, 3'd0, 0, 6'h02);
    chk("R5 irq stays", {31'd0, irq}, 32'd1);
    // R6 event in the same cycle as the clearing read
    cyc(1, 0, 0, 3'd1, 0, 6'h04);
    chk("R6 read returns old bits", {16'd0, reg_rdata}, 32'h3);
    chk("R6 irq gap", {31'd0, irq}, 32'd0);
    idle();
    chk("R6 irq returns", {31'd0, irq}, 32'd1);
    cyc(1, 1, 0, 3'd1, 0, 0);
    chk("R6 kept bit", {16'd0, reg_rdata}, 32'h4);

    // R7 write to status ignored
    cyc(0, 0, 1, 3'd1, 16'hFFFF, 0);
    cyc(1, 1, 0, 3'd1, 0, 0);
    chk("R7 status unchanged", {16'd0, reg_rdata}, 32'h4);
    cyc(1, 0, 0, 3'd1, 0, 0);
    cyc(0, 0, 1, 3'd1, 16'h003F, 0);
    chk("R7 irq stays low", {31'd0, irq}, 32'd0);
    cyc(1, 1, 0, 3'd1, 0, 0);
    chk("R7 status zero", {16'd0, reg_rdata}, 32'h0);

    // R8 address pairs
    cyc(0, 0, 1, 3'd2, 16'h1234, 0);
    cyc(0, 0, 1, 3'd3, 16'hABCD, 0);
    cyc(0, 0, 1, 3'd4, 16'h5678, 0);
    cyc(0, 0, 1, 3'd5, 16'h9ABC, 0);
    chk("R8 src_addr", src_addr, 32'hABCD1234);
    chk("R8 dst_addr", dst_addr, 32'h9ABC5678);
    cyc(1, 0, 0, 3'd3, 0, 0); chk("R8 src hi read", {16'd0, reg_rdata}, 32'hABCD);
    cyc(1, 0, 0, 3'd4, 0, 0); chk("R8 dst lo read", {16'd0, reg_rdata}, 32'h5678);

    // R9 upper bits and unmapped addresses
    cyc(0, 0, 1, 3'd0, 16'hFFFF, 0);
    cyc(1, 0, 0, 3'd0, 0, 0); chk("R9 ctrl upper zero", {16'd0, reg_rdata}, 32'h003F);
    cyc(0, 0, 0, 3'd0, 0, 6'h3F);
    cyc(1, 1, 0, 3'd1, 0, 0); chk("R9 status upper zero", {16'd0, reg_rdata}, 32'h003F);
    cyc(1, 0, 0, 3'd6, 0, 0); chk("R9 addr 6", {16'd0, reg_rdata}, 32'h0);
    cyc(1, 0, 0, 3'd7, 0, 0); chk("R9 addr 7", {16'd0, reg_rdata}, 32'h0);

    // R1 reset again clears status and irq
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    cyc(1, 1, 0, 3'd1, 0, 0); chk("R1 status after reset", {16'd0, reg_rdata}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule